// File: doc/BRIEF.md
# Two-Channel Word Merger with Per-Line Check Codes

This block takes one pair of pixel words at a time, one from each of two converter channels, and turns them into a single output word stream, two words per pair. Alongside the data lane it drives a second lane of synchronization codes. These codes mark where frames and lines begin and end, and they tag the check words.

For each channel, the block keeps a running 10-bit cyclic check code over every word of the current line. When a line closes, it appends the two check words after the line's last data word, first channel A's and then channel B's. A mode input selects full 10-bit words or narrowed 8-bit words.

The upstream source marks the first and last pair of each line. With those marks it flags whether the line opens or closes a frame. A pair must not arrive sooner than two cycles after the previous pair, or sooner than four cycles after the last pair of a line. The block ignores a pair that arrives while it is still busy.

Top module: `dual_lane_crc_formatter`

## Requirements
- R1: While reset is held and right after it, `outValid` is 0, `outData` is 0 and `outSync` is the idle code 10'h000.
- R2: When the block accepts a pair on a clock edge, channel A's word appears on `outData` after that edge (even slot). Channel B's word follows one cycle later (odd slot).
- R3: When `mode8` is 0, a data word is output unchanged. When `mode8` is 1, it is output as {2'b00, word[9:2]}.
- R4: Each channel has its own check code. It is CRC-10 with polynomial 10'h25B (x^10+x^9+x^6+x^4+x^3+x+1), fed MSB first, one bit per step: feedback = crc[9] xor bit, crc shifts left, and POLY is XORed in when the feedback is 1. The code is seeded with 10'h3FF on the pair that has `inFirst` set. In 8-bit mode only bits 9..2 of each word are fed.
- R5: In the cycle after the B word of a pair that has `inLast` set, `outData` carries channel A's full 10-bit check code. Channel B's follows in the next cycle. In both of these cycles `outSync` is 10'h0F5.
- R6: The A word of a pair with `inFirst` set carries line start 10'h2C1 on `outSync`, or frame start 10'h3C1 when `inFrameFirst` is also set. The B word of a pair with `inLast` set carries line end 10'h2E1, or frame end 10'h3E1 when `inFrameLast` is also set. A line of only one pair carries both markings.
- R7: In every other cycle, including plain data words and empty cycles, `outSync` carries the idle code 10'h000.
- R8: A pair with `inValid` high in a cycle when the block is still emitting a B word or a check word is ignored. It does not change the output stream or either check code.
- R9: `outValid` is 1 exactly in the cycles that carry a data word or a check word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| mode8 | input | 1 | 1 selects 8-bit words, 0 selects 10-bit words |
| inValid | input | 1 | A word pair is present |
| inFirst | input | 1 | The pair is the first of its line |
| inLast | input | 1 | The pair is the last of its line |
| inFrameFirst | input | 1 | With inFirst: the line opens a frame |
| inFrameLast | input | 1 | With inLast: the line closes a frame |
| inA | input | 10 | Channel A word |
| inB | input | 10 | Channel B word |
| outValid | output | 1 | outData carries a word |
| outData | output | 10 | Merged data or check word |
| outSync | output | 10 | Synchronization code lane |

## Verification
The bench builds the block with its default parameters: 10-bit words, two dropped bits in narrow mode, and a 10-bit check code with its polynomial and all-ones seed. These defaults put both word widths and every sync code within reach, at full check width. Random frames mix line lengths, modes and idle gaps. Directed lines cover single-pair lines, all-ones and all-zero words, and pairs injected while the block is busy.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  localparam int SYNC_W = 10;

  localparam logic [SYNC_W-1:0] CODE_IDLE = 10'h000;
  localparam logic [SYNC_W-1:0] CODE_FS   = 10'h3C1;
  localparam logic [SYNC_W-1:0] CODE_LS   = 10'h2C1;
  localparam logic [SYNC_W-1:0] CODE_LE   = 10'h2E1;
  localparam logic [SYNC_W-1:0] CODE_FE   = 10'h3E1;
  localparam logic [SYNC_W-1:0] CODE_CRC  = 10'h0F5;

  typedef enum logic [2:0] {
    SYN_IDLE = 3'd0,
    SYN_FS   = 3'd1,
    SYN_LS   = 3'd2,
    SYN_LE   = 3'd3,
    SYN_FE   = 3'd4,
    SYN_CRC  = 3'd5
  } syncSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     loadPair;
    logic     seedCrc;
    logic     emitA;
    logic     emitB;
    logic     emitCrcA;
    logic     emitCrcB;
    syncSel_t syncSel;
  } fmtStrobe_t;

endpackage

// File: rtl/fmt_crc_lane.sv
module fmt_crc_lane #(
  parameter int DATA_W = 10,
  parameter int CRC_W = 10,
  parameter int DROP_W = 2,
  parameter logic [CRC_W-1:0] CRC_POLY = 10'h25B,
  parameter logic [CRC_W-1:0] CRC_SEED = 10'h3FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              seed,
  input  logic              narrow,
  input  logic [DATA_W-1:0] word,
  output logic [CRC_W-1:0]  crc
);

  function automatic logic [CRC_W-1:0] crcStep(
    input logic [CRC_W-1:0]  cur,
    input logic [DATA_W-1:0] w,
    input logic              nar
  );
    logic [CRC_W-1:0] r;
    logic fb;
    r = cur;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (!(nar && (i < DROP_W))) begin
        fb = r[CRC_W-1] ^ w[i];
        r = {r[CRC_W-2:0], 1'b0};
        if (fb) r = r ^ CRC_POLY;
      end
    end
    return r;
  endfunction

  logic [CRC_W-1:0] base;
  assign base = seed ? CRC_SEED : crc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crc <= CRC_SEED;
    end else if (load) begin
      crc <= crcStep(base, word, narrow);
    end
  end

  // R4: without a load the check code holds
  a_r4_crc_holds: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> $stable(crc));

endmodule

// File: rtl/fmt_ctrl.sv
module fmt_ctrl
  import fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inFirst,
  input  logic       inLast,
  input  logic       inFrameFirst,
  input  logic       inFrameLast,
  output fmtStrobe_t strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_B, ST_CA, ST_CB} state_t;

  state_t state, nextState;
  logic   lastQ, frameLastQ;

  always_comb begin
    strb = '0;
    strb.syncSel = SYN_IDLE;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (inValid) begin
          strb.loadPair = 1'b1;
          strb.seedCrc  = inFirst;
          strb.emitA    = 1'b1;
          if (inFirst) strb.syncSel = inFrameFirst ? SYN_FS : SYN_LS;
          nextState = ST_B;
        end
      end
      ST_B: begin
        strb.emitB = 1'b1;
        if (lastQ) strb.syncSel = frameLastQ ? SYN_FE : SYN_LE;
        nextState = lastQ ? ST_CA : ST_IDLE;
      end
      ST_CA: begin
        strb.emitCrcA = 1'b1;
        strb.syncSel  = SYN_CRC;
        nextState = ST_CB;
      end
      default: begin
        strb.emitCrcB = 1'b1;
        strb.syncSel  = SYN_CRC;
        nextState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      lastQ      <= 1'b0;
      frameLastQ <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.loadPair) begin
        lastQ      <= inLast;
        frameLastQ <= inFrameLast;
      end
    end
  end

  // R2: the B word follows an accepted pair in the next slot
  a_r2_b_after_a: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPair |=> strb.emitB);

  // R2: at most one word source per cycle
  a_r2_one_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.emitA, strb.emitB, strb.emitCrcA, strb.emitCrcB}));

  // R5: check word B follows check word A
  a_r5_crcb_after_crca: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitCrcA |=> strb.emitCrcB);

  // R8: a pair seen during a busy cycle is not loaded on the next edge
  a_r8_busy_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emitA || strb.emitCrcA) |=> !strb.loadPair);

endmodule

// File: rtl/fmt_datapath.sv
module fmt_datapath
  import fmt_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CRC_W = 10,
  parameter int DROP_W = 2,
  parameter logic [CRC_W-1:0] CRC_POLY = 10'h25B,
  parameter logic [CRC_W-1:0] CRC_SEED = 10'h3FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtStrobe_t        strb,
  input  logic              mode8,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [SYNC_W-1:0] outSync
);

  localparam int LANES = 2;
  localparam int NARROW_W = DATA_W - DROP_W;

  logic [DATA_W-1:0]            bHold;
  logic [LANES-1:0][DATA_W-1:0] laneWord;
  logic [LANES-1:0][CRC_W-1:0]  laneCrc;

  assign laneWord[0] = inA;
  assign laneWord[1] = inB;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    fmt_crc_lane #(
      .DATA_W(DATA_W), .CRC_W(CRC_W), .DROP_W(DROP_W),
      .CRC_POLY(CRC_POLY), .CRC_SEED(CRC_SEED)
    ) uLane (
      .clk(clk), .rstN(rstN),
      .load(strb.loadPair), .seed(strb.seedCrc), .narrow(mode8),
      .word(laneWord[g]), .crc(laneCrc[g])
    );
  end

  function automatic logic [DATA_W-1:0] shapeWord(input logic [DATA_W-1:0] w, input logic nar);
    return nar ? DATA_W'(w[DATA_W-1:DROP_W]) : w;
  endfunction

  function automatic logic [SYNC_W-1:0] codeOf(input syncSel_t s);
    case (s)
      SYN_FS:  return CODE_FS;
      SYN_LS:  return CODE_LS;
      SYN_LE:  return CODE_LE;
      SYN_FE:  return CODE_FE;
      SYN_CRC: return CODE_CRC;
      default: return CODE_IDLE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bHold    <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outSync  <= CODE_IDLE;
    end else begin
      if (strb.loadPair) bHold <= inB;
      outValid <= strb.emitA | strb.emitB | strb.emitCrcA | strb.emitCrcB;
      outSync  <= codeOf(strb.syncSel);
      if (strb.emitA)         outData <= shapeWord(inA, mode8);
      else if (strb.emitB)    outData <= shapeWord(bHold, mode8);
      else if (strb.emitCrcA) outData <= DATA_W'(laneCrc[0]);
      else if (strb.emitCrcB) outData <= DATA_W'(laneCrc[1]);
      else                    outData <= '0;
    end
  end

  // R7: no word means idle sync
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outSync == CODE_IDLE));

  // R3: narrow A words leave the upper bits clear
  a_r3_narrow_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emitA && mode8) |=> (outData[DATA_W-1:NARROW_W] == '0));

  // R9: a B word slot always raises the valid flag
  a_r9_valid_on_b: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitB |=> outValid);

endmodule

// File: rtl/dual_lane_crc_formatter.sv
module dual_lane_crc_formatter
  import fmt_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CRC_W = 10,
  parameter int DROP_W = 2,
  parameter logic [CRC_W-1:0] CRC_POLY = 10'h25B,
  parameter logic [CRC_W-1:0] CRC_SEED = 10'h3FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode8,
  input  logic              inValid,
  input  logic              inFirst,
  input  logic              inLast,
  input  logic              inFrameFirst,
  input  logic              inFrameLast,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [SYNC_W-1:0] outSync
);

  fmtStrobe_t strb;

  fmt_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inFirst(inFirst), .inLast(inLast),
    .inFrameFirst(inFrameFirst), .inFrameLast(inFrameLast),
    .strb(strb)
  );

  fmt_datapath #(
    .DATA_W(DATA_W), .CRC_W(CRC_W), .DROP_W(DROP_W),
    .CRC_POLY(CRC_POLY), .CRC_SEED(CRC_SEED)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .mode8(mode8),
    .inA(inA), .inB(inB),
    .outValid(outValid), .outData(outData), .outSync(outSync)
  );

  // R5: two check words follow the end-of-line marking
  a_r5_crc_after_end: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ((outSync == CODE_LE) || (outSync == CODE_FE))) |=> (outValid && (outSync == CODE_CRC)));

endmodule

// File: tb/dual_lane_crc_formatter_test.sv
module dual_lane_crc_formatter_test;

  localparam logic [9:0] E_IDLE = 10'h000;
  localparam logic [9:0] E_FS   = 10'h3C1;
  localparam logic [9:0] E_LS   = 10'h2C1;
  localparam logic [9:0] E_LE   = 10'h2E1;
  localparam logic [9:0] E_FE   = 10'h3E1;
  localparam logic [9:0] E_CRC  = 10'h0F5;
  localparam logic [9:0] POLY   = 10'h25B;
  localparam logic [9:0] SEED   = 10'h3FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mode8 = 1'b0;
  logic inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic inFrameFirst = 1'b0, inFrameLast = 1'b0;
  logic [9:0] inA = '0, inB = '0;
  logic outValid;
  logic [9:0] outData, outSync;

  int nChecks = 0;
  int nFail = 0;
  logic [9:0] eCrcA = SEED, eCrcB = SEED;

  always #5 clk = ~clk;

  dual_lane_crc_formatter uut (
    .clk(clk), .rstN(rstN), .mode8(mode8),
    .inValid(inValid), .inFirst(inFirst), .inLast(inLast),
    .inFrameFirst(inFrameFirst), .inFrameLast(inFrameLast),
    .inA(inA), .inB(inB),
    .outValid(outValid), .outData(outData), .outSync(outSync)
  );

  function automatic logic [9:0] refCrc(input logic [9:0] c, input logic [9:0] w, input logic nar);
    logic [9:0] r = c;
    int top = 9;
    int bot = nar ? 2 : 0;
    for (int i = top; i >= bot; i--) begin
      if (r[9] != w[i]) r = {r[8:0], 1'b0} ^ POLY;
      else r = {r[8:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [9:0] refWord(input logic [9:0] w, input logic nar);
    return nar ? {2'b00, w[9:2]} : w;
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic junkDrive();
    inValid = 1'b1; inFirst = 1'b1; inLast = 1'b1;
    inFrameFirst = 1'b1; inFrameLast = 1'b1;
    inA = 10'($urandom); inB = 10'($urandom);
  endtask

  task automatic clearDrive();
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
    inFrameFirst = 1'b0; inFrameLast = 1'b0;
  endtask

  // Entered and left at a negative edge
  task automatic sendPair(input logic [9:0] a, input logic [9:0] b, input logic first,
                          input logic last, input logic ff, input logic fl, input logic junk);
    logic [9:0] expS;
    inValid = 1'b1; inFirst = first; inLast = last;
    inFrameFirst = ff; inFrameLast = fl; inA = a; inB = b;
    @(negedge clk);
    eCrcA = refCrc(first ? SEED : eCrcA, a, mode8);
    eCrcB = refCrc(first ? SEED : eCrcB, b, mode8);
    expS = first ? (ff ? E_FS : E_LS) : E_IDLE;
    chk("R2 A word valid", {9'd0, outValid}, 10'd1);
    chk("R2/R3 A word", outData, refWord(a, mode8));
    chk("R6/R7 A sync", outSync, expS);
    if (junk) junkDrive(); else clearDrive();
    @(negedge clk);
    expS = last ? (fl ? E_FE : E_LE) : E_IDLE;
    chk("R2 B word valid", {9'd0, outValid}, 10'd1);
    chk("R2/R3/R8 B word", outData, refWord(b, mode8));
    chk("R6/R7 B sync", outSync, expS);
    if (!last) clearDrive();
    if (last) begin
      @(negedge clk);
      chk("R5 check A valid", {9'd0, outValid}, 10'd1);
      chk("R4/R5/R8 check A", outData, eCrcA);
      chk("R5 check A sync", outSync, E_CRC);
      @(negedge clk);
      chk("R5 check B valid", {9'd0, outValid}, 10'd1);
      chk("R4/R5/R8 check B", outData, eCrcB);
      chk("R5 check B sync", outSync, E_CRC);
      clearDrive();
    end
  endtask

  task automatic idleGap();
    clearDrive();
    @(negedge clk);
    chk("R9 idle valid", {9'd0, outValid}, 10'd0);
    chk("R7 idle sync", outSync, E_IDLE);
  endtask

  task automatic sendLine(input int n, input logic ff, input logic fl, input int junkPct, input int gapPct);
    for (int i = 0; i < n; i++) begin
      sendPair(10'($urandom), 10'($urandom), i == 0, i == n - 1,
               ff, fl, ($urandom % 100) < junkPct);
      if (($urandom % 100) < gapPct) idleGap();
    end
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {9'd0, outValid}, 10'd0);
    chk("R1 reset data", outData, 10'd0);
    chk("R1 reset sync", outSync, E_IDLE);
    rstN = 1'b1;
    idleGap();

    // Directed: one-pair line opening and closing a frame, 10-bit
    mode8 = 1'b0;
    sendPair(10'h3FF, 10'h000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    idleGap();
    // Directed: one-pair line, 8-bit, plain line marks, busy injection
    mode8 = 1'b1;
    sendPair(10'h3FF, 10'h3FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    // Directed: back-to-back pairs with busy injection on each
    mode8 = 1'b0;
    sendPair(10'h155, 10'h2AA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    sendPair(10'h000, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    sendPair(10'h001, 10'h200, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    idleGap();

    // Random frames
    for (int f = 0; f < 40; f++) begin
      int lines = 1 + int'($urandom % 4);
      mode8 = 1'($urandom);
      for (int l = 0; l < lines; l++) begin
        sendLine(1 + int'($urandom % 6), l == 0, l == lines - 1, 30, 30);
        if (($urandom % 2) == 1) idleGap();
      end
    end
    idleGap();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule